// File: doc/BRIEF.md
# Virtual-Channel State Field Guard with Spare Substitution

This block holds the per-virtual-channel bookkeeping fields of a router input port and keeps them usable when individual fields suffer permanent faults. The fields fall into two groups. The control group holds the channel's global state, its route, its assigned output channel and its credit count. The pointer group holds the head and tail buffer pointers. Each group owns one spare register. The spare of the control group is as wide as the widest control field. The spare of the pointer group is as wide as one pointer.

An external self-test unit presents two fault vectors, one bit per field. When exactly one field of a group is flagged, all writes and reads of that field are steered to the group's spare, and the damaged primary register is no longer written. When two or more fields of one group are flagged, the spare cannot cover them. The block then closes the channel. It raises a closing signal toward the upstream allocator, stops accepting state updates, and presents an idle, zero-credit channel.

A small health machine tracks the channel. It has three states. HEALTHY means no fault bit is set. SPARED means at least one fault bit is set but no group has more than one. CLOSED means a group has two or more fault bits set. The transitions are:
- go_spared: HEALTHY to SPARED.
- go_healthy: SPARED to HEALTHY.
- go_closed: from HEALTHY or SPARED to CLOSED.

CLOSED has no exit other than reset.

Top module: `vc_field_guard`

## Requirements
- R1: After reset, every field output reads zero and `vc_closed` is low.
- R2: With no fault bit set, a field whose write enable is high reads the written value from the next cycle on.
- R3: Control fault bits map bit0 to global state, bit1 to route, bit2 to output channel and bit3 to credit, and write enables use the same order. A flagged field is written to and read from the control spare, and its primary register keeps its old value, which reappears once the flag clears. If several bits are set, the lowest-numbered one owns the spare.
- R4: A field narrower than the control spare is stored in it zero-extended. A read through the spare returns only that field's width, so a spare holding 9 read as global state (3 bits) gives 1.
- R5: Pointer fault bits map bit0 to head and bit1 to tail. A flagged pointer uses the pointer spare in the same way, independently of the control group.
- R6: Two or more fault bits set in one group raise `vc_closed` from the next cycle. A write presented in that same cycle still takes effect.
- R7: `vc_closed` stays high until reset, even after the fault bits clear.
- R8: While `vc_closed` is high, all field writes are ignored.
- R9: While `vc_closed` is high, the global state output reads the idle code 0 and the credit output reads 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| g1_fault | input | 4 | Control-group fault flags |
| g2_fault | input | 2 | Pointer-group fault flags |
| g1_wen | input | 4 | Control-group write enables |
| g2_wen | input | 2 | Pointer-group write enables |
| gst_in | input | G_W | Next global state |
| route_in | input | R_W | Next route |
| ovc_in | input | O_W | Next output channel |
| cred_in | input | C_W | Next credit count |
| hptr_in | input | PTR_W | Next head pointer |
| tptr_in | input | PTR_W | Next tail pointer |
| gst_out | output | G_W | Global state |
| route_out | output | R_W | Route |
| ovc_out | output | O_W | Output channel |
| cred_out | output | C_W | Credit count |
| hptr_out | output | PTR_W | Head pointer |
| tptr_out | output | PTR_W | Tail pointer |
| vc_closed | output | 1 | Channel closed toward upstream allocation |

## Verification
The sharp case is a state update that arrives in the same cycle as a second fault flag in one group. The closing decision is registered, so the update must land and the channel must close one edge later. The bench provokes this by setting two control flags while writing all four control fields. After that edge it expects `vc_closed` high, the route to hold the value just written, and the global state and credit to be masked. A following write with the channel closed must leave every field unchanged.

// File: rtl/vfg_pkg.sv
package vfg_pkg;

    typedef enum logic [1:0] {
        HEALTHY = 2'd0,
        SPARED  = 2'd1,
        CLOSED  = 2'd2
    } health_e;

    function automatic int unsigned max2(input int unsigned a, input int unsigned b);
        return (a > b) ? a : b;
    endfunction

endpackage

// File: rtl/vfg_group.sv
module vfg_group #(
    parameter int unsigned N = 4,
    parameter int unsigned W = 4,
    parameter logic [N*W-1:0] FMASK = '1
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic [N-1:0]        fault,
    input  logic [N-1:0]        we,
    input  logic [N-1:0][W-1:0] wdata,
    input  logic                block,
    output logic [N-1:0][W-1:0] rdata,
    output logic                any_fault,
    output logic                multi_fault
);

    logic [N-1:0][W-1:0] prim_q;
    logic [W-1:0]        spare_q;
    logic [N-1:0]        sel;
    logic                found;

    // lowest flagged field owns the spare
    always_comb begin
        sel   = '0;
        found = 1'b0;
        for (int i = 0; i < N; i++) begin
            if (fault[i] && !found) begin
                sel[i] = 1'b1;
                found  = 1'b1;
            end
        end
    end

    assign any_fault   = |fault;
    assign multi_fault = (fault & (fault - 1'b1)) != '0;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            prim_q  <= '0;
            spare_q <= '0;
        end else if (!block) begin
            for (int i = 0; i < N; i++) begin
                if (we[i] && !sel[i]) prim_q[i] <= wdata[i] & FMASK[i*W +: W];
                if (we[i] && sel[i])  spare_q   <= wdata[i] & FMASK[i*W +: W];
            end
        end
    end

    for (genvar i = 0; i < N; i++) begin : g_rd
        assign rdata[i] = sel[i] ? (spare_q & FMASK[i*W +: W]) : prim_q[i];
    end

endmodule

// File: rtl/vfg_health.sv
module vfg_health
    import vfg_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic any_fault,
    input  logic multi_fault,
    output logic closed
);

    health_e state_q, state_d;

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            HEALTHY: begin
                if (multi_fault)    state_d = CLOSED;
                else if (any_fault) state_d = SPARED;
            end
            SPARED: begin
                if (multi_fault)     state_d = CLOSED;
                else if (!any_fault) state_d = HEALTHY;
            end
            CLOSED:  state_d = CLOSED;
            default: state_d = HEALTHY;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) state_q <= HEALTHY;
        else        state_q <= state_d;
    end

    always_comb begin
        closed = (state_q == CLOSED);
    end

endmodule

// File: rtl/vc_field_guard.sv
module vc_field_guard #(
    parameter int unsigned G_W   = 3,
    parameter int unsigned R_W   = 3,
    parameter int unsigned O_W   = 2,
    parameter int unsigned C_W   = 4,
    parameter int unsigned PTR_W = 2
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [3:0]       g1_fault,
    input  logic [1:0]       g2_fault,
    input  logic [3:0]       g1_wen,
    input  logic [1:0]       g2_wen,
    input  logic [G_W-1:0]   gst_in,
    input  logic [R_W-1:0]   route_in,
    input  logic [O_W-1:0]   ovc_in,
    input  logic [C_W-1:0]   cred_in,
    input  logic [PTR_W-1:0] hptr_in,
    input  logic [PTR_W-1:0] tptr_in,
    output logic [G_W-1:0]   gst_out,
    output logic [R_W-1:0]   route_out,
    output logic [O_W-1:0]   ovc_out,
    output logic [C_W-1:0]   cred_out,
    output logic [PTR_W-1:0] hptr_out,
    output logic [PTR_W-1:0] tptr_out,
    output logic             vc_closed
);
    import vfg_pkg::*;

    localparam int unsigned SP1_W = max2(max2(G_W, R_W), max2(O_W, C_W));
    localparam logic [SP1_W-1:0] MSK_G = {SP1_W{1'b1}} >> (SP1_W - G_W);
    localparam logic [SP1_W-1:0] MSK_R = {SP1_W{1'b1}} >> (SP1_W - R_W);
    localparam logic [SP1_W-1:0] MSK_O = {SP1_W{1'b1}} >> (SP1_W - O_W);
    localparam logic [SP1_W-1:0] MSK_C = {SP1_W{1'b1}} >> (SP1_W - C_W);
    localparam logic [4*SP1_W-1:0] G1_MASK = {MSK_C, MSK_O, MSK_R, MSK_G};

    logic [3:0][SP1_W-1:0] g1_wd, g1_rd;
    logic [1:0][PTR_W-1:0] g2_wd, g2_rd;
    logic g1_any, g1_multi, g2_any, g2_multi;
    logic unused_rd;

    assign g1_wd = {SP1_W'(cred_in), SP1_W'(ovc_in), SP1_W'(route_in), SP1_W'(gst_in)};
    assign g2_wd = {tptr_in, hptr_in};

    vfg_group #(.N(4), .W(SP1_W), .FMASK(G1_MASK)) u_grp_ctl (
        .clk(clk), .rst_n(rst_n), .fault(g1_fault), .we(g1_wen), .wdata(g1_wd),
        .block(vc_closed), .rdata(g1_rd), .any_fault(g1_any), .multi_fault(g1_multi)
    );

    vfg_group #(.N(2), .W(PTR_W), .FMASK({2*PTR_W{1'b1}})) u_grp_ptr (
        .clk(clk), .rst_n(rst_n), .fault(g2_fault), .we(g2_wen), .wdata(g2_wd),
        .block(vc_closed), .rdata(g2_rd), .any_fault(g2_any), .multi_fault(g2_multi)
    );

    vfg_health u_health (
        .clk(clk), .rst_n(rst_n),
        .any_fault(g1_any | g2_any),
        .multi_fault(g1_multi | g2_multi),
        .closed(vc_closed)
    );

    assign unused_rd = ^{g1_rd, g2_rd};

    assign gst_out   = vc_closed ? '0 : g1_rd[0][G_W-1:0];
    assign route_out = g1_rd[1][R_W-1:0];
    assign ovc_out   = g1_rd[2][O_W-1:0];
    assign cred_out  = vc_closed ? '0 : g1_rd[3][C_W-1:0];
    assign hptr_out  = g2_rd[0];
    assign tptr_out  = g2_rd[1];

endmodule

// File: rtl/vfg_guard_chk.sv
module vfg_guard_chk #(
    parameter int unsigned G_W   = 3,
    parameter int unsigned R_W   = 3,
    parameter int unsigned O_W   = 2,
    parameter int unsigned C_W   = 4,
    parameter int unsigned PTR_W = 2
) (
    input logic             clk,
    input logic             rst_n,
    input logic [3:0]       g1_fault,
    input logic [1:0]       g2_fault,
    input logic [3:0]       g1_wen,
    input logic [1:0]       g2_wen,
    input logic [R_W-1:0]   route_in,
    input logic [PTR_W-1:0] hptr_in,
    input logic [G_W-1:0]   gst_out,
    input logic [R_W-1:0]   route_out,
    input logic [O_W-1:0]   ovc_out,
    input logic [C_W-1:0]   cred_out,
    input logic [PTR_W-1:0] hptr_out,
    input logic [PTR_W-1:0] tptr_out,
    input logic             vc_closed
);

    // R2
    healthy_write_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!vc_closed && g1_fault == 4'b0000 && g1_wen[1])
        |=> (g1_fault != 4'b0000 || route_out == $past(route_in)));

    // R5
    ptr_spare_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!vc_closed && g2_fault == 2'b01 && g2_wen[0])
        |=> (g2_fault != 2'b01 || vc_closed || hptr_out == $past(hptr_in)));

    // R6
    close_on_double_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ($countones(g1_fault) > 1 || g2_fault == 2'b11) |=> vc_closed);

    // R7
    close_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
        vc_closed |=> vc_closed);

    // R8
    closed_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (vc_closed && $past(vc_closed) && $stable(g1_fault) && $stable(g2_fault))
        |-> ($stable(route_out) && $stable(ovc_out) && $stable(hptr_out) && $stable(tptr_out)));

    // R9
    closed_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
        vc_closed |-> (gst_out == '0 && cred_out == '0));

endmodule

bind vc_field_guard vfg_guard_chk #(
    .G_W(G_W), .R_W(R_W), .O_W(O_W), .C_W(C_W), .PTR_W(PTR_W)
) u_guard_chk (
    .clk(clk), .rst_n(rst_n), .g1_fault(g1_fault), .g2_fault(g2_fault),
    .g1_wen(g1_wen), .g2_wen(g2_wen), .route_in(route_in), .hptr_in(hptr_in),
    .gst_out(gst_out), .route_out(route_out), .ovc_out(ovc_out), .cred_out(cred_out),
    .hptr_out(hptr_out), .tptr_out(tptr_out), .vc_closed(vc_closed)
);

// File: tb/test_vc_field_guard.sv
module test_vc_field_guard;

    localparam int CLK_PERIOD = 10;
    localparam int NVEC = 8;

    // {fault[3:0], wen[3:0], val[3:0], exp_gst[2:0], exp_route[2:0], exp_ovc[1:0], exp_cred[3:0]}
    localparam logic [23:0] VEC [NVEC] = '{
        {4'b0000, 4'b1111, 4'hF, 3'd7, 3'd7, 2'd3, 4'd15},
        {4'b0010, 4'b0010, 4'h5, 3'd7, 3'd5, 2'd3, 4'd15},
        {4'b0000, 4'b0000, 4'h0, 3'd7, 3'd7, 2'd3, 4'd15},
        {4'b0100, 4'b0100, 4'hE, 3'd7, 3'd7, 2'd2, 4'd15},
        {4'b0001, 4'b0000, 4'h0, 3'd2, 3'd7, 2'd3, 4'd15},
        {4'b1000, 4'b1001, 4'h9, 3'd1, 3'd7, 2'd3, 4'd9},
        {4'b0001, 4'b0000, 4'h0, 3'd1, 3'd7, 2'd3, 4'd15},
        {4'b0000, 4'b1111, 4'h0, 3'd0, 3'd0, 2'd0, 4'd0}
    };

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic [3:0] g1_fault = '0, g1_wen = '0;
    logic [1:0] g2_fault = '0, g2_wen = '0;
    logic [2:0] gst_in = '0, route_in = '0;
    logic [1:0] ovc_in = '0;
    logic [3:0] cred_in = '0;
    logic [1:0] hptr_in = '0, tptr_in = '0;
    logic [2:0] gst_out, route_out;
    logic [1:0] ovc_out, hptr_out, tptr_out;
    logic [3:0] cred_out;
    logic       vc_closed;

    int checks = 0;
    int errors = 0;

    always #(CLK_PERIOD/2) clk = ~clk;

    vc_field_guard i_vc_field_guard (
        .clk(clk), .rst_n(rst_n), .g1_fault(g1_fault), .g2_fault(g2_fault),
        .g1_wen(g1_wen), .g2_wen(g2_wen), .gst_in(gst_in), .route_in(route_in),
        .ovc_in(ovc_in), .cred_in(cred_in), .hptr_in(hptr_in), .tptr_in(tptr_in),
        .gst_out(gst_out), .route_out(route_out), .ovc_out(ovc_out), .cred_out(cred_out),
        .hptr_out(hptr_out), .tptr_out(tptr_out), .vc_closed(vc_closed)
    );

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic set_g1(input logic [3:0] v);
        gst_in = v[2:0]; route_in = v[2:0]; ovc_in = v[1:0]; cred_in = v;
    endtask

    initial begin
        repeat (20000) @(posedge clk);
        errors++;
        $display("FAIL watchdog actual=timeout expected=done");
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        // R1 reset state
        chk("R1 fields", {gst_out, route_out, ovc_out, cred_out, hptr_out, tptr_out}, 0);
        chk("R1 closed", vc_closed, 0);

        // table walk: R2 R3 R4
        for (int k = 0; k < NVEC; k++) begin
            g1_fault = VEC[k][23:20];
            g1_wen   = VEC[k][19:16];
            set_g1(VEC[k][15:12]);
            @(negedge clk);
            chk($sformatf("R2 R3 R4 entry %0d", k),
                {gst_out, route_out, ovc_out, cred_out}, {8'h0, VEC[k][11:0]});
        end
        g1_wen = '0; g1_fault = '0;

        // R5 pointer spare
        g2_fault = 2'b01; g2_wen = 2'b11; hptr_in = 2'd3; tptr_in = 2'd2;
        @(negedge clk);
        chk("R5 head via spare", hptr_out, 3);
        chk("R5 tail primary", tptr_out, 2);
        g2_fault = 2'b00; g2_wen = 2'b00;
        @(negedge clk);
        chk("R5 head primary untouched", hptr_out, 0);

        // R6 double fault with coincident write
        g1_fault = 4'b0011; g1_wen = 4'b1111;
        gst_in = 3'd5; route_in = 3'd5; ovc_in = 2'd1; cred_in = 4'd5;
        @(negedge clk);
        chk("R6 closed", vc_closed, 1);
        chk("R6 coincident write", route_out, 5);
        chk("R9 idle gst", gst_out, 0);
        chk("R9 zero credit", cred_out, 0);

        // R8 writes ignored while closed
        route_in = 3'd2; ovc_in = 2'd3; cred_in = 4'd7;
        g2_wen = 2'b11; hptr_in = 2'd3; tptr_in = 2'd3;
        @(negedge clk);
        chk("R8 route held", route_out, 5);
        chk("R8 ovc held", ovc_out, 1);
        chk("R8 ptrs held", {hptr_out, tptr_out}, {2'd0, 2'd2});
        chk("R9 credit masked", cred_out, 0);

        // R7 sticky
        g1_fault = 4'b0000; g1_wen = '0; g2_wen = '0;
        repeat (2) @(negedge clk);
        chk("R7 sticky", vc_closed, 1);

        // R1 reset reopens
        rst_n = 1'b0;
        repeat (2) @(negedge clk);
        rst_n = 1'b1;
        chk("R1 reopened", vc_closed, 0);
        chk("R1 route cleared", route_out, 0);

        // R6 pointer group double
        g2_fault = 2'b11;
        @(negedge clk);
        chk("R6 ptr double closes", vc_closed, 1);

        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

endmodule